// File: doc/BRIEF.md
# Platform-Level Interrupt Controller Core

This block gathers a parameterised set of external interrupt sources and spreads them over several hart contexts. A context is one privilege level, such as machine or supervisor, on one hardware thread. Each context has its own request line toward its hart. Every source sits behind a gateway. The gateway turns a raw level or edge input into a single pending request and holds back further requests while a handler owns that source. The design has a per-source priority register, a per-source per-context enable bit, and a per-context priority threshold.

Software works the block through a narrow register port. One write strobe carries a 2-bit kind code, a context index, a source index and a data byte. A separate claim strobe names a context and returns the winning source ID one cycle later. When the handler finishes, it writes a completion naming the source, which releases it. Source IDs run from 1 to `NSRC`, and ID 0 means "nothing". A per-source parameter mask makes each input level or edge sensitive. A second mask chooses, for each edge source, whether edges seen during service are counted and replayed later or thrown away.

Top module: `plic_core`

## Requirements
- R1: After reset, `irq_o` is all zero, `claim_id_o` is 0, and every priority, enable bit and threshold is 0. A claim issued in this state returns 0.
- R2: Write kind 1 sets or clears the enable bit of (`cfg_ctx`, `cfg_src`) from `cfg_data[0]`. A source whose enable bit is clear for a context never raises that context's line and is never returned by that context's claim.
- R3: Write kind 0 sets the priority of `cfg_src`, and write kind 2 sets the threshold of `cfg_ctx`. Both values come from `cfg_data[PRIO_W-1:0]`. A source raises a context's line only if its priority is strictly greater than that context's threshold. A priority of 0 therefore never interrupts, and a priority equal to the threshold is masked.
- R4: Among qualifying sources, a claim returns the one with the highest priority. When priorities are equal, the lowest source ID wins.
- R5: A claim on `claim_ctx` puts its result on `claim_id_o` in the cycle after `claim_en`. In the same clock it clears that source's pending bit. When nothing qualifies, the result is 0. When no claim was made in the previous cycle, `claim_id_o` is 0.
- R6: A level source makes no new request between its claim and its completion, even while its input stays high. If the input is still high after the completion, the source becomes pending again.
- R7: A completion is write kind 3, with the source ID in `cfg_data[ID_W-1:0]`. A completion naming a source that is not currently claimed is ignored: a pending source stays pending and its queued edge count is unchanged.
- R8: An edge source with its bit set in `QUEUE_MASK` counts rising edges in a counter `CNT_W` bits wide. The counter saturates at 2^CNT_W-1. Each completion decrements it, and if the result is nonzero the source becomes pending again.
- R9: An edge source with its bit clear in `QUEUE_MASK` drops rising edges that arrive while it is claimed. After its completion it stays idle until a new edge arrives.
- R10: Each context drives its own line. Enable and threshold settings of one context do not affect another context's line. A claim by any context removes the source from every context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Raw interrupt inputs; bit i is source ID i |
| irq_o | output | NCTX | Interrupt request line per context |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 2 | 0 priority, 1 enable, 2 threshold, 3 completion |
| cfg_ctx | input | CTX_W | Context addressed by enable, threshold and completion writes |
| cfg_src | input | ID_W | Source addressed by priority and enable writes |
| cfg_data | input | DATA_W | Write data: priority, threshold, enable bit 0, or completed ID |
| claim_en | input | 1 | Claim strobe |
| claim_ctx | input | CTX_W | Context issuing the claim |
| claim_id_o | output | ID_W | Claimed source ID, valid the cycle after `claim_en` |

## Verification
The properties take for granted that `claim_ctx` always names an existing context. They also assume that no cycle carries both a claim and a completion for the same source, since the gateways give the claim precedence in that case. The stimulus drives only one strobe per cycle and uses context indices below `NCTX`, so both assumptions hold throughout. Source inputs change only on the falling clock edge and stay high for a full cycle, so every pulse is a clean rising edge that the gateways see.

// File: rtl/plic_pkg.sv
package plic_pkg;

  typedef enum logic [1:0] {
    CFG_PRIO     = 2'd0,
    CFG_ENABLE   = 2'd1,
    CFG_THRESH   = 2'd2,
    CFG_COMPLETE = 2'd3
  } cfg_kind_e;

  // A candidate beats the current bar only when strictly above it; this
  // gives both the threshold mask and the lowest-ID tie break.
  function automatic logic outranks(input int unsigned cand, input int unsigned bar);
    return cand > bar;
  endfunction

  // Edge counter update: a rising edge adds one up to the ceiling, a
  // completion then removes one.
  function automatic int unsigned queue_next(input int unsigned cnt, input logic inc,
                                             input logic dec, input int unsigned cmax);
    int unsigned v;
    v = cnt;
    if (inc && v < cmax) v = v + 1;
    if (dec && v != 0) v = v - 1;
    return v;
  endfunction

endpackage

// File: rtl/plic_gateway.sv
module plic_gateway
  import plic_pkg::*;
#(
  parameter bit EDGE  = 1'b0,
  parameter bit QUEUE = 1'b0,
  parameter int CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic claim_i,
  input  logic complete_i,
  output logic pend_o,
  output logic active_o
);

  localparam int unsigned CMAX = (1 << CNT_W) - 1;

  logic pend_q;
  logic act_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          act_q <= 1'b0;
    else if (claim_i)    act_q <= 1'b1;
    else if (complete_i) act_q <= 1'b0;
  end

  generate
    if (!EDGE) begin : g_level
      always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (claim_i)          pend_q <= 1'b0;
        else if (src_i && !act_q)  pend_q <= 1'b1;
      end
    end else begin : g_edge
      logic src_d;
      logic rise_w;
      always_ff @(posedge clk) begin
        if (!rst_n) src_d <= 1'b0;
        else        src_d <= src_i;
      end
      assign rise_w = src_i & ~src_d;

      if (QUEUE) begin : g_queue
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] cnt_n;
        assign cnt_n = CNT_W'(queue_next(32'(cnt_q), rise_w, complete_i, CMAX));
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            cnt_q  <= '0;
            pend_q <= 1'b0;
          end else begin
            cnt_q <= cnt_n;
            if (claim_i)               pend_q <= 1'b0;
            else if (complete_i)       pend_q <= (cnt_n != '0);
            else if (rise_w && !act_q) pend_q <= 1'b1;
          end
        end
      end else begin : g_drop
        always_ff @(posedge clk) begin
          if (!rst_n)                 pend_q <= 1'b0;
          else if (claim_i)           pend_q <= 1'b0;
          else if (rise_w && !act_q)  pend_q <= 1'b1;
        end
      end
    end
  endgenerate

  assign pend_o   = pend_q;
  assign active_o = act_q;

endmodule

// File: rtl/plic_target_arb.sv
module plic_target_arb
  import plic_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic [NSRC:1][PRIO_W-1:0] prio_i,
  input  logic [NSRC:1]             pend_i,
  input  logic [NSRC:1]             en_i,
  input  logic [PRIO_W-1:0]         thr_i,
  output logic [ID_W-1:0]           best_id_o
);

  logic [PRIO_W-1:0] bar;

  always_comb begin
    bar       = thr_i;
    best_id_o = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (pend_i[i] && en_i[i] && outranks(32'(prio_i[i]), 32'(bar))) begin
        bar       = prio_i[i];
        best_id_o = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_pkg::*;
#(
  parameter int NSRC   = 8,
  parameter int NCTX   = 2,
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 2,
  parameter int DATA_W = 8,
  parameter logic [NSRC-1:0] EDGE_MASK  = 'hF0,
  parameter logic [NSRC-1:0] QUEUE_MASK = 'h30,
  localparam int ID_W  = $clog2(NSRC + 1),
  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_i,
  output logic [NCTX-1:0]   irq_o,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_kind,
  input  logic [CTX_W-1:0]  cfg_ctx,
  input  logic [ID_W-1:0]   cfg_src,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              claim_en,
  input  logic [CTX_W-1:0]  claim_ctx,
  output logic [ID_W-1:0]   claim_id_o
);

  logic [NSRC:1][PRIO_W-1:0] prio_q;
  logic [NCTX-1:0][NSRC:1]   en_q;
  logic [NCTX-1:0][PRIO_W-1:0] thr_q;
  logic [NCTX-1:0][ID_W-1:0] best_w;
  logic [NSRC:1]             pend_w, act_w, claim_w, done_w;
  logic [ID_W-1:0]           claim_pick_w, claim_id_q, done_id_w;
  cfg_kind_e                 kind_w;
  logic                      src_ok_w, cfg_ctx_ok_w, claim_ctx_ok_w;
  logic                      wr_prio_w, wr_en_w, wr_thr_w, wr_done_w;

  assign kind_w         = cfg_kind_e'(cfg_kind);
  assign src_ok_w       = (cfg_src != '0) && (32'(cfg_src) <= NSRC);
  assign cfg_ctx_ok_w   = 32'(cfg_ctx) < NCTX;
  assign claim_ctx_ok_w = 32'(claim_ctx) < NCTX;
  assign wr_prio_w      = cfg_we && kind_w == CFG_PRIO   && src_ok_w;
  assign wr_en_w        = cfg_we && kind_w == CFG_ENABLE && src_ok_w && cfg_ctx_ok_w;
  assign wr_thr_w       = cfg_we && kind_w == CFG_THRESH && cfg_ctx_ok_w;
  assign wr_done_w      = cfg_we && kind_w == CFG_COMPLETE;
  assign done_id_w      = cfg_data[ID_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else begin
      if (wr_prio_w) prio_q[cfg_src]        <= cfg_data[PRIO_W-1:0];
      if (wr_en_w)   en_q[cfg_ctx][cfg_src] <= cfg_data[0];
      if (wr_thr_w)  thr_q[cfg_ctx]         <= cfg_data[PRIO_W-1:0];
    end
  end

  genvar c;
  generate
    for (c = 0; c < NCTX; c++) begin : g_ctx
      plic_target_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .prio_i   (prio_q),
        .pend_i   (pend_w),
        .en_i     (en_q[c]),
        .thr_i    (thr_q[c]),
        .best_id_o(best_w[c])
      );
      assign irq_o[c] = best_w[c] != '0;
    end
  endgenerate

  assign claim_pick_w = (claim_en && claim_ctx_ok_w) ? best_w[claim_ctx] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) claim_id_q <= '0;
    else        claim_id_q <= claim_pick_w;
  end
  assign claim_id_o = claim_id_q;

  genvar s;
  generate
    for (s = 1; s <= NSRC; s++) begin : g_src
      assign claim_w[s] = claim_pick_w == ID_W'(s);
      assign done_w[s]  = wr_done_w && done_id_w == ID_W'(s) && act_w[s];
      plic_gateway #(
        .EDGE (EDGE_MASK[s-1]),
        .QUEUE(QUEUE_MASK[s-1]),
        .CNT_W(CNT_W)
      ) u_gw (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i[s]),
        .claim_i   (claim_w[s]),
        .complete_i(done_w[s]),
        .pend_o    (pend_w[s]),
        .active_o  (act_w[s])
      );
    end
  endgenerate

endmodule

// File: rtl/plic_core_sva.sv
module plic_core_sva #(
  parameter int NSRC  = 8,
  parameter int NCTX  = 2,
  parameter int ID_W  = 4,
  parameter int CTX_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCTX-1:0]  irq,
  input logic             claim_en,
  input logic [CTX_W-1:0] claim_ctx,
  input logic [ID_W-1:0]  claim_id,
  input logic [NSRC:1]    pend,
  input logic [NSRC:1]    act
);

  a_r5_id_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_id != '0) |-> $past(claim_en));

  a_r5_grant_when_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && irq[claim_ctx]) |=> (claim_id != '0));

  a_r5_zero_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_en && !irq[claim_ctx]) |=> (claim_id == '0));

  a_r6_claimed_is_active: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_id != '0) |-> act[claim_id]);

  a_r6_no_pend_while_active: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & act) == '0);

  a_r2_line_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (pend != '0));

endmodule

bind plic_core plic_core_sva #(
  .NSRC(NSRC), .NCTX(NCTX), .ID_W(ID_W), .CTX_W(CTX_W)
) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq_o),
  .claim_en (claim_en),
  .claim_ctx(claim_ctx),
  .claim_id (claim_id_o),
  .pend     (pend_w),
  .act      (act_w)
);

// File: tb/tb_plic_core.sv
module tb_plic_core;

  localparam int NSRC = 8;
  localparam int NCTX = 2;
  localparam logic [1:0] K_PRIO = 2'd0, K_EN = 2'd1, K_THR = 2'd2, K_DONE = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:1]  src_i = '0;
  logic [1:0]  irq_o;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [0:0]  cfg_ctx = '0;
  logic [3:0]  cfg_src = '0;
  logic [7:0]  cfg_data = '0;
  logic        claim_en = 1'b0;
  logic [0:0]  claim_ctx = '0;
  logic [3:0]  claim_id_o;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  plic_core dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .irq_o(irq_o),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_ctx(cfg_ctx), .cfg_src(cfg_src),
    .cfg_data(cfg_data), .claim_en(claim_en), .claim_ctx(claim_ctx),
    .claim_id_o(claim_id_o)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] k, input int ctx, input int src, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_ctx = 1'(ctx); cfg_src = 4'(src); cfg_data = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_irq(input int ctx, input logic exp, input string tag);
    check(irq_o[ctx] == exp, tag, int'(irq_o[ctx]), int'(exp));
  endtask

  // Driver: issues a claim and pushes the expected ID into the scoreboard.
  task automatic do_claim(input int ctx, input int exp, input string tag);
    @(negedge clk);
    claim_en = 1'b1; claim_ctx = 1'(ctx);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    claim_en = 1'b0;
  endtask

  task automatic pulse(input int s);
    @(negedge clk); src_i[s] = 1'b1;
    @(negedge clk); src_i[s] = 1'b0;
  endtask

  // Monitor: the ID appears the cycle after the claim strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (claim_en) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected claim", int'(claim_id_o), -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'(claim_id_o) == e, t, int'(claim_id_o), e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq_o == 2'b00, "R1 reset irq", int'(irq_o), 0);
    check(claim_id_o == 4'd0, "R1 reset claim id", int'(claim_id_o), 0);
    do_claim(0, 0, "R1 claim after reset");

    // Priority 0 never interrupts, even when enabled
    src_i[1] = 1'b1;
    cfg_write(K_EN, 0, 1, 1);
    settle();
    chk_irq(0, 1'b0, "R3 priority zero masked");
    cfg_write(K_PRIO, 0, 1, 3);
    settle();
    chk_irq(0, 1'b1, "R3 priority above threshold");
    chk_irq(1, 1'b0, "R2 not enabled for ctx1");
    cfg_write(K_THR, 0, 0, 3);
    settle();
    chk_irq(0, 1'b0, "R3 equal to threshold masked");
    cfg_write(K_THR, 0, 0, 2);
    settle();
    chk_irq(0, 1'b1, "R3 threshold lowered");

    // Arbitration with a tie at priority 5
    cfg_write(K_PRIO, 0, 2, 5);
    cfg_write(K_PRIO, 0, 3, 5);
    cfg_write(K_EN, 0, 2, 1);
    cfg_write(K_EN, 0, 3, 1);
    src_i[2] = 1'b1; src_i[3] = 1'b1;
    settle();
    do_claim(0, 2, "R4 tie goes to lowest id");
    do_claim(0, 3, "R4 next of equal priority");
    do_claim(0, 1, "R4 lower priority last");
    do_claim(0, 0, "R5 nothing qualifies");
    settle();
    chk_irq(0, 1'b0, "R6 held level makes no request while claimed");

    cfg_write(K_DONE, 0, 0, 2);
    settle();
    chk_irq(0, 1'b1, "R6 level re-pends after completion");
    do_claim(0, 2, "R6 reclaim held level");
    src_i[1] = 1'b0; src_i[2] = 1'b0; src_i[3] = 1'b0;
    cfg_write(K_DONE, 0, 0, 1);
    cfg_write(K_DONE, 0, 0, 2);
    cfg_write(K_DONE, 0, 0, 3);
    settle();
    chk_irq(0, 1'b0, "R6 released low levels stay idle");

    // Queue mode on source 5, context 1
    cfg_write(K_PRIO, 0, 5, 1);
    cfg_write(K_EN, 1, 5, 1);
    pulse(5);
    settle();
    chk_irq(1, 1'b1, "R8 edge raises ctx1");
    chk_irq(0, 1'b0, "R10 ctx0 unaffected");
    cfg_write(K_DONE, 1, 0, 5);
    settle();
    chk_irq(1, 1'b1, "R7 completion of unclaimed source ignored");
    do_claim(1, 5, "R7 source still claimable");
    pulse(5); pulse(5); pulse(5);
    settle();
    chk_irq(1, 1'b0, "R8 queued edges wait for completion");
    cfg_write(K_DONE, 1, 0, 5);
    settle();
    do_claim(1, 5, "R8 first replay");
    cfg_write(K_DONE, 1, 0, 5);
    settle();
    do_claim(1, 5, "R8 second replay at saturation");
    cfg_write(K_DONE, 1, 0, 5);
    settle();
    chk_irq(1, 1'b0, "R8 counter drained");
    do_claim(1, 0, "R8 no further replay");

    // Ignore mode on source 7
    cfg_write(K_PRIO, 0, 7, 2);
    cfg_write(K_EN, 1, 7, 1);
    pulse(7);
    settle();
    do_claim(1, 7, "R9 edge claimed");
    pulse(7); pulse(7);
    cfg_write(K_DONE, 1, 0, 7);
    settle();
    chk_irq(1, 1'b0, "R9 edges during service dropped");
    do_claim(1, 0, "R9 nothing replayed");

    // Contexts independent; a claim removes the source everywhere
    cfg_write(K_EN, 1, 1, 1);
    cfg_write(K_THR, 1, 0, 4);
    src_i[1] = 1'b1;
    settle();
    chk_irq(0, 1'b1, "R10 ctx0 raised");
    chk_irq(1, 1'b0, "R10 ctx1 threshold masks only ctx1");
    cfg_write(K_THR, 1, 0, 2);
    settle();
    chk_irq(1, 1'b1, "R10 ctx1 raised");
    do_claim(1, 1, "R10 ctx1 claims shared source");
    settle();
    chk_irq(0, 1'b0, "R10 claim clears ctx0 too");
    chk_irq(1, 1'b0, "R5 claim clears pending");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule